// File: doc/BRIEF.md
# Program Counter Sequencer with Interrupt Vectoring

This block chooses the next fetch address of a small microcontroller core. Each clock it either loads a subroutine target, restores a return address, jumps to a fixed interrupt vector or steps the address by one. Return addresses are kept in a private hardware stack of eight levels that software can neither read nor write.

Three interrupt sources are supported: an external pin and two timer overflows. Each source sets its own request flag, and that flag stays set until the source is acknowledged. A source is taken only when its flag and its enable bit are set, the global enable is on, and the stack has a free level. If the stack is full, the request waits. It is acknowledged in the cycle right after a return frees a level.

The global enable is held as the state of a two-state machine. ST_RUN means interrupts may be taken. ST_MASKED means an acknowledge has happened and no return-from-interrupt has been seen yet. Reset enters ST_RUN. Transition T_ACK goes from ST_RUN to ST_MASKED when an interrupt is acknowledged. Transition T_RETI goes from either state to ST_RUN on a return-from-interrupt strobe. A plain return or a call leaves the state unchanged.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is low and in the first cycle after it, `pc_o` is 0x0000, `irq_ack_o` and `call_ovf_o` are 0 and `stack_full_o` is 0.
- R2: With no strobe and no interrupt taken, `pc_o` increments by one per cycle when `advance_i` is 1 and holds when it is 0.
- R3: A call with a free stack level pushes the current `pc_o` and loads `call_tgt_i`. A later return (`ret_i` or `reti_i`) loads the most recently pushed value, in last-in first-out order.
- R4: The stack holds 8 entries. `stack_full_o` is 1 exactly when 8 entries are stored.
- R5: A call while the stack is full raises `call_ovf_o` for one cycle, leaves `pc_o` unchanged and leaves every stored entry intact.
- R6: An acknowledge raises `irq_ack_o` for one cycle. In that cycle `pc_o` is the vector and `irq_src_o` is the source code: external pin is code 0 and vector 0x0004, timer 0 is code 1 and vector 0x0008, timer 1 is code 2 and vector 0x000C. Bit i of `irq_req_i` and `irq_en_i` belongs to source code i.
- R7: A request pulse is latched. A source whose enable is 0 is not taken, but its request stays pending and is taken once the enable is set.
- R8: When several enabled requests are pending, code 0 is taken before code 1, and code 1 before code 2.
- R9: An acknowledge clears that source's request and enters ST_MASKED. No further acknowledge happens until `reti_i` returns the machine to ST_RUN.
- R10: No acknowledge happens while the stack is full. A pending request is acknowledged in the cycle after a return frees a level.
- R11: In one cycle a return wins over a call, a call wins over an interrupt, and an interrupt wins over `advance_i`. The deferred interrupt stays pending.
- R12: A return with an empty stack leaves `pc_o` unchanged. `reti_i` still sets ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| advance_i | input | 1 | Step the fetch address by one |
| call_i | input | 1 | Subroutine call strobe |
| call_tgt_i | input | 16 | Call target address |
| ret_i | input | 1 | Subroutine return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_req_i | input | 3 | Request pulses, one bit per source |
| irq_en_i | input | 3 | Per-source enable bits |
| pc_o | output | 16 | Current fetch address |
| irq_ack_o | output | 1 | One-cycle acknowledge pulse |
| irq_src_o | output | 2 | Source code of the acknowledge |
| stack_full_o | output | 1 | All eight stack levels are used |
| call_ovf_o | output | 1 | One-cycle flag for a call made with a full stack |

## Verification
Directed sequences drive the address steps, calls nested to full depth, and an overflowing call followed by eight pops. Checking the eight popped values tells a dropped call apart from an overwritten entry. Other directed cases raise each source alone, all three at once, a disabled source that is later enabled, and a request made while masked. Together these separate vector selection, priority order, latching and the masking state. Further cases hold a request against a full stack and strobe return, call and interrupt in the same cycle, which exposes the release timing and the precedence order. Random traffic then mixes all of these cases, and a cycle-accurate bench model predicts every output.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    // ST_RUN: global interrupt enable on; ST_MASKED: inside a service routine
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_MASKED = 1'b1
    } pcs_state_e;
endpackage

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [W-1:0]    mem [DEPTH];
    logic [SP_W-1:0] sp;
    logic [SP_W-1:0] sp_m1;

    assign sp_m1 = sp - SP_W'(1);
    assign full  = (sp == SP_W'(DEPTH));
    assign empty = (sp == '0);
    assign dout  = mem[sp_m1[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push && !full) begin
            sp <= sp + SP_W'(1);
        end else if (pop && !empty) begin
            sp <= sp_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[sp[IDX_W-1:0]] <= din;
        end
    end
endmodule

// File: rtl/pcs_irq_arb.sv
module pcs_irq_arb #(
    parameter int N     = 3,
    parameter int SRC_W = 2
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     en,
    input  logic             allow,
    output logic             grant_v,
    output logic [SRC_W-1:0] grant_idx,
    output logic [N-1:0]     grant_oh
);
    logic [N-1:0] live;

    assign live = pend & en;

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        grant_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                grant_idx = SRC_W'(i);
            end
        end
        grant_v  = allow && (|live);
        grant_oh = grant_v ? (N'(1) << grant_idx) : '0;
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 8,
    parameter int N_IRQ       = 3,
    parameter int VEC_STRIDE  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     advance_i,
    input  logic                     call_i,
    input  logic [PC_W-1:0]          call_tgt_i,
    input  logic                     ret_i,
    input  logic                     reti_i,
    input  logic [N_IRQ-1:0]         irq_req_i,
    input  logic [N_IRQ-1:0]         irq_en_i,
    output logic [PC_W-1:0]          pc_o,
    output logic                     irq_ack_o,
    output logic [$clog2(N_IRQ)-1:0] irq_src_o,
    output logic                     stack_full_o,
    output logic                     call_ovf_o
);
    import pcs_pkg::*;

    localparam int SRC_W = $clog2(N_IRQ);

    pcs_state_e       state_q, state_d;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic             ack_q, ack_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic             ovf_q, ovf_d;

    logic             push, pop;
    logic [PC_W-1:0]  stk_top;
    logic             stk_full, stk_empty;

    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] clr;
    logic             allow;
    logic             grant_v;
    logic [SRC_W-1:0] grant_idx;
    logic [N_IRQ-1:0] grant_oh;
    logic [PC_W-1:0]  vec_addr;

    pcs_ret_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (pc_q),
        .dout  (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    pcs_irq_arb #(.N(N_IRQ), .SRC_W(SRC_W)) u_arb (
        .pend      (pend_q),
        .en        (irq_en_i),
        .allow     (allow),
        .grant_v   (grant_v),
        .grant_idx (grant_idx),
        .grant_oh  (grant_oh)
    );

    // One latched request flag per source; a fresh pulse outranks a clear.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else begin
                pend_q[g] <= (pend_q[g] && !clr[g]) || irq_req_i[g];
            end
        end
    end

    assign vec_addr = (PC_W'(grant_idx) + PC_W'(1)) * PC_W'(VEC_STRIDE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and next outputs
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        ack_d   = 1'b0;
        src_d   = src_q;
        ovf_d   = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        clr     = '0;

        unique case (state_q)
            ST_RUN:    allow = !stk_full;
            ST_MASKED: allow = 1'b0;
            default:   allow = 1'b0;
        endcase

        if (ret_i || reti_i) begin
            if (!stk_empty) begin
                pop  = 1'b1;
                pc_d = stk_top;
            end
            if (reti_i) begin
                state_d = ST_RUN;                 // T_RETI
            end
        end else if (call_i) begin
            if (!stk_full) begin
                push = 1'b1;
                pc_d = call_tgt_i;
            end else begin
                ovf_d = 1'b1;
            end
        end else if (grant_v) begin
            push    = 1'b1;
            pc_d    = vec_addr;
            ack_d   = 1'b1;
            src_d   = grant_idx;
            clr     = grant_oh;
            state_d = ST_MASKED;                  // T_ACK
        end else if (advance_i) begin
            pc_d = pc_q + PC_W'(1);
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ack_q <= 1'b0;
            src_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            pc_q  <= pc_d;
            ack_q <= ack_d;
            src_q <= src_d;
            ovf_q <= ovf_d;
        end
    end

    assign pc_o         = pc_q;
    assign irq_ack_o    = ack_q;
    assign irq_src_o    = src_q;
    assign stack_full_o = stk_full;
    assign call_ovf_o   = ovf_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int PC_W       = 16,
    parameter int SRC_W      = 2,
    parameter int N_IRQ      = 3,
    parameter int VEC_STRIDE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_i,
    input logic             ret_i,
    input logic             reti_i,
    input logic [PC_W-1:0]  pc_o,
    input logic             irq_ack_o,
    input logic [SRC_W-1:0] irq_src_o,
    input logic             stack_full_o,
    input logic             call_ovf_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && !irq_ack_o && !call_ovf_o && !stack_full_o));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_full_o && call_i && !ret_i && !reti_i) |=> call_ovf_o);

    assert_quiet_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !call_i |=> !call_ovf_o);

    assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> (32'(irq_src_o) < N_IRQ &&
                       pc_o == (PC_W'(irq_src_o) + PC_W'(1)) * PC_W'(VEC_STRIDE)));

    assert_single_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o);

    assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full_o |=> !irq_ack_o);
endmodule

bind pc_sequencer pcs_checker #(
    .PC_W(PC_W), .SRC_W($clog2(N_IRQ)), .N_IRQ(N_IRQ), .VEC_STRIDE(VEC_STRIDE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .reti_i       (reti_i),
    .pc_o         (pc_o),
    .irq_ack_o    (irq_ack_o),
    .irq_src_o    (irq_src_o),
    .stack_full_o (stack_full_o),
    .call_ovf_o   (call_ovf_o)
);

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance_i = 1'b0;
    logic        call_i = 1'b0;
    logic [15:0] call_tgt_i = '0;
    logic        ret_i = 1'b0;
    logic        reti_i = 1'b0;
    logic [2:0]  irq_req_i = '0;
    logic [2:0]  irq_en_i = '0;
    logic [15:0] pc_o;
    logic        irq_ack_o;
    logic [1:0]  irq_src_o;
    logic        stack_full_o;
    logic        call_ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model state
    logic [15:0] m_pc;
    logic [15:0] m_stk [8];
    int          m_dep;
    logic [2:0]  m_pend;
    bit          m_gie;
    bit          m_ack;
    logic [1:0]  m_src;
    bit          m_ovf;

    always #4 clk = ~clk;   // 125 MHz

    pc_sequencer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance_i    (advance_i),
        .call_i       (call_i),
        .call_tgt_i   (call_tgt_i),
        .ret_i        (ret_i),
        .reti_i       (reti_i),
        .irq_req_i    (irq_req_i),
        .irq_en_i     (irq_en_i),
        .pc_o         (pc_o),
        .irq_ack_o    (irq_ack_o),
        .irq_src_o    (irq_src_o),
        .stack_full_o (stack_full_o),
        .call_ovf_o   (call_ovf_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input logic [1:0] s);
        return 16'((s + 1) * 4);
    endfunction

    task automatic model_reset();
        m_pc = '0; m_dep = 0; m_pend = '0; m_gie = 1'b1;
        m_ack = 1'b0; m_src = '0; m_ovf = 1'b0;
    endtask

    // One clock edge of the required behaviour (R2..R12)
    task automatic model_edge();
        logic [2:0] live;
        live = m_pend & irq_en_i;
        m_ack = 1'b0;
        m_ovf = 1'b0;
        if (ret_i || reti_i) begin
            if (m_dep > 0) begin
                m_dep--;
                m_pc = m_stk[m_dep];
            end
            if (reti_i) m_gie = 1'b1;
        end else if (call_i) begin
            if (m_dep < 8) begin
                m_stk[m_dep] = m_pc;
                m_dep++;
                m_pc = call_tgt_i;
            end else begin
                m_ovf = 1'b1;
            end
        end else if (m_gie && m_dep < 8 && live != 3'b000) begin
            m_src = live[0] ? 2'd0 : (live[1] ? 2'd1 : 2'd2);
            m_stk[m_dep] = m_pc;
            m_dep++;
            m_pc = vec_of(m_src);
            m_ack = 1'b1;
            m_pend[m_src] = 1'b0;
            m_gie = 1'b0;
        end else if (advance_i) begin
            m_pc = m_pc + 16'd1;
        end
        m_pend = m_pend | irq_req_i;
    endtask

    task automatic compare(input string req);
        check(pc_o == m_pc, req, "pc", pc_o, m_pc);
        check(irq_ack_o == m_ack, req, "ack", 16'(irq_ack_o), 16'(m_ack));
        if (m_ack) check(irq_src_o == m_src, req, "src", 16'(irq_src_o), 16'(m_src));
        check(stack_full_o == (m_dep == 8), req, "full", 16'(stack_full_o), 16'(m_dep == 8));
        check(call_ovf_o == m_ovf, req, "ovf", 16'(call_ovf_o), 16'(m_ovf));
    endtask

    // Called at a falling edge: drive, take one rising edge, compare at the next falling edge.
    task automatic step(input bit adv, input bit cl, input logic [15:0] tgt,
                        input bit rt, input bit rti, input logic [2:0] req,
                        input string tag);
        advance_i = adv; call_i = cl; call_tgt_i = tgt;
        ret_i = rt; reti_i = rti; irq_req_i = req;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        advance_i = 1'b0; call_i = 1'b0; ret_i = 1'b0; reti_i = 1'b0; irq_req_i = '0;
        compare(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] saved [8];
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1");
        check(pc_o == 16'h0000, "R1", "pc after reset", pc_o, 16'h0000);

        // R2: stepping and holding
        repeat (5) step(1, 0, 0, 0, 0, 0, "R2");
        check(pc_o == 16'h0005, "R2", "pc after 5 steps", pc_o, 16'h0005);
        repeat (3) step(0, 0, 0, 0, 0, 0, "R2");

        // R3: nested calls and LIFO return
        step(0, 1, 16'h0100, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 16'h0200, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, "R3");
        check(pc_o == 16'h0101, "R3", "inner return", pc_o, 16'h0101);
        step(0, 0, 0, 1, 0, 0, "R3");
        check(pc_o == 16'h0005, "R3", "outer return", pc_o, 16'h0005);

        // R4/R5: fill the stack, overflow, then drain
        for (int i = 0; i < 8; i++) begin
            saved[i] = pc_o;
            step(0, 1, 16'(16'h1000 + i * 16'h0100), 0, 0, 0, "R4");
        end
        check(stack_full_o == 1'b1, "R4", "full after 8", 16'(stack_full_o), 16'h1);
        step(0, 1, 16'h9FFF, 0, 0, 0, "R5");
        check(call_ovf_o == 1'b1 && pc_o == 16'h1700, "R5", "overflow call", pc_o, 16'h1700);
        for (int i = 7; i >= 0; i--) begin
            step(0, 0, 0, 1, 0, 0, "R5");
            check(pc_o == saved[i], "R5", "drain entry", pc_o, saved[i]);
        end

        // R12: return on empty stack
        step(0, 0, 0, 1, 0, 0, "R12");
        check(pc_o == 16'h0005, "R12", "empty return", pc_o, 16'h0005);

        // R6/R9: each source alone
        irq_en_i = 3'b111;
        for (int s = 0; s < 3; s++) begin
            step(0, 0, 0, 0, 0, 3'(1 << s), "R6");
            step(0, 0, 0, 0, 0, 0, "R6");
            check(irq_ack_o && irq_src_o == 2'(s) && pc_o == vec_of(2'(s)),
                  "R6", "vector", pc_o, vec_of(2'(s)));
            step(1, 0, 0, 0, 0, 3'(1 << s), "R9");
            step(1, 0, 0, 0, 0, 0, "R9");
            check(!irq_ack_o, "R9", "masked", 16'(irq_ack_o), 16'h0);
            step(0, 0, 0, 0, 1, 0, "R9");
            step(0, 0, 0, 0, 0, 0, "R9");
            check(irq_ack_o && irq_src_o == 2'(s), "R9", "taken after reti", 16'(irq_src_o), 16'(s));
            step(0, 0, 0, 0, 1, 0, "R9");
        end

        // R8: all three together
        step(0, 0, 0, 0, 0, 3'b111, "R8");
        for (int s = 0; s < 3; s++) begin
            step(0, 0, 0, 0, 0, 0, "R8");
            check(irq_ack_o && irq_src_o == 2'(s), "R8", "priority order", 16'(irq_src_o), 16'(s));
            step(0, 0, 0, 0, 1, 0, "R8");
        end

        // R7: disabled source stays latched
        irq_en_i = 3'b011;
        step(1, 0, 0, 0, 0, 3'b100, "R7");
        repeat (3) step(1, 0, 0, 0, 0, 0, "R7");
        check(!irq_ack_o, "R7", "disabled not taken", 16'(irq_ack_o), 16'h0);
        irq_en_i = 3'b111;
        step(0, 0, 0, 0, 0, 0, "R7");
        check(irq_ack_o && irq_src_o == 2'd2, "R7", "taken once enabled", 16'(irq_src_o), 16'h2);
        step(0, 0, 0, 0, 1, 0, "R7");

        // R10: pending request against a full stack
        for (int i = 0; i < 8; i++) step(0, 1, 16'(16'h2000 + i), 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 3'b010, "R10");
        repeat (3) step(0, 0, 0, 0, 0, 0, "R10");
        check(!irq_ack_o, "R10", "held while full", 16'(irq_ack_o), 16'h0);
        step(0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        check(irq_ack_o && irq_src_o == 2'd1, "R10", "released after return", 16'(irq_src_o), 16'h1);
        step(0, 0, 0, 0, 1, 0, "R10");
        for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 0, 0, "R10");

        // R11: same-cycle precedence
        step(0, 1, 16'h0300, 1, 0, 0, "R11");          // return wins, stack empty -> hold
        step(1, 1, 16'h0400, 0, 0, 3'b001, "R11");      // call wins over advance
        step(1, 0, 0, 0, 0, 0, "R11");                   // interrupt wins over advance
        check(irq_ack_o && pc_o == 16'h0004, "R11", "deferred interrupt", pc_o, 16'h0004);
        step(0, 0, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 1, 0, 0, "R11");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit a, c, rt, rti;
            logic [2:0] q;
            r   = int'($urandom_range(0, 99));
            c   = (r < 15);
            rt  = (r >= 15 && r < 24);
            rti = (r >= 24 && r < 30);
            a   = ($urandom_range(0, 9) < 7);
            q   = 3'($urandom_range(0, 7)) & {($urandom_range(0, 9) == 0),
                                              ($urandom_range(0, 9) == 0),
                                              ($urandom_range(0, 9) == 0)};
            if ($urandom_range(0, 49) == 0) irq_en_i = 3'($urandom_range(0, 7));
            step(a, c, 16'($urandom_range(0, 16'h9FFF)), rt, rti, q, "R11");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule